// File: doc/BRIEF.md
# Scan Queue Trigger Status Logic

This block keeps the status of one conversion queue inside a queued ADC sequencer. It follows whether the queue is running a scan, and it raises three sticky flags: the queue finished, the queue paused, and a trigger overrun. Queue progress arrives as single-cycle strobes from the sequencer. Trigger events come from a rising edge on the external trigger pin or from a tick of the periodic timer.

The meaning of an overrun depends on the scan mode. In the triggered modes, an overrun is a trigger that arrives while a scan is still running. That trigger is discarded and does not change the scan. In gated continuous mode, an overrun is a second end of queue while the gate is open, and it counts only if the completion flag was not cleared after the first one. Software reads the flags over a simple register port. A flag clears only when software writes 0 to it after it has read that flag as 1. Each flag has an interrupt output that is masked by its own enable.

Top module: `qscan_flag_unit`

## Requirements
- R1: After a synchronous reset, all flags, all read-armed bits, the active state and `rdata_o` are 0.
- R2: `active_o` goes to 1 on the cycle after `start_i`. Otherwise it goes to 0 on the cycle after `pause_i` or `eoq_i`. If `start_i` arrives in the same cycle as an end strobe, `start_i` wins.
- R3: In a triggered mode, a trigger event that arrives while `active_o` is 1 sets the overrun flag (bit 2) on the next cycle. The event leaves `active_o` unchanged.
- R4: In pin modes (`mode_i` 3 and 4), a trigger event is a 0-to-1 change of `pin_i`. In timer modes (`mode_i` 5 and 6), a trigger event is `tick_i`.
- R5: In modes 0, 1 and 2 (off, software single, software continuous), pin edges and timer ticks never set the overrun flag.
- R6: In gated mode (`mode_i` 7), `pin_i` acts as the gate. An `eoq_i` that arrives while `pin_i` is 1 and the completion flag (bit 0) is already 1 sets the overrun flag. Pin edges and ticks do not set it in this mode.
- R7: `eoq_i` sets the completion flag (bit 0) and `pause_i` sets the pause flag (bit 1), in every mode and whatever the interrupt enables are.
- R8: When `rd_i` is high, `rdata_o` takes the flag values on the next cycle, and each flag that was 1 becomes armed. A later write with a 0 in an armed flag's bit clears that flag.
- R9: Writing 0 to a flag that is not armed leaves it unchanged. Writing 1 never changes a flag.
- R10: If a flag sets in the same cycle as a valid clear, the flag stays 1. A new set also disarms that flag.
- R11: `irq_o[i]` equals `flags_o[i] & irq_en_i[i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 3 | Scan mode: 0 off, 1 software single, 2 software continuous, 3 pin single, 4 pin continuous, 5 timer single, 6 timer continuous, 7 gated continuous |
| pin_i | input | 1 | External trigger pin; acts as the gate in mode 7 |
| tick_i | input | 1 | Periodic timer tick |
| start_i | input | 1 | Scan-started strobe |
| pause_i | input | 1 | Pause-reached strobe |
| eoq_i | input | 1 | End-of-queue strobe |
| rd_i | input | 1 | Status read strobe |
| wr_i | input | 1 | Status write strobe |
| wdata_i | input | 3 | Write data; a 0 bit requests a clear |
| irq_en_i | input | 3 | Per-flag interrupt enables |
| rdata_o | output | 3 | Read data, valid the cycle after `rd_i` |
| flags_o | output | 3 | Flags: bit 0 completion, bit 1 pause, bit 2 overrun |
| irq_o | output | 3 | Masked interrupt requests |
| active_o | output | 1 | Queue is scanning |

## Verification
A wrong active state shows up one cycle after the next trigger event: the overrun flag either sets when it should not, or fails to set. A read-armed bit that is stuck on or stuck off shows up on the first write of 0 after it, because the flag then clears when it should hold, or holds when it should clear. Every output is compared with a reference model on every cycle, so a wrong flag or active bit is reported within one cycle of its first visible effect. Directed sequences cover the gated double end of queue, the collision between a set and a clear, and the software modes.

// File: rtl/qscan_pkg.sv
package qscan_pkg;
  typedef enum logic [2:0] {
    M_OFF      = 3'd0,
    M_SW_ONCE  = 3'd1,
    M_SW_LOOP  = 3'd2,
    M_PIN_ONCE = 3'd3,
    M_PIN_LOOP = 3'd4,
    M_TMR_ONCE = 3'd5,
    M_TMR_LOOP = 3'd6,
    M_GATED    = 3'd7
  } scan_mode_e;

  localparam int FLAG_N     = 3;
  localparam int FLAG_DONE  = 0;
  localparam int FLAG_PAUSE = 1;
  localparam int FLAG_OVR   = 2;
endpackage

// File: rtl/qscan_trig_ctl.sv
module qscan_trig_ctl
  import qscan_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] mode_i,
  input  logic       pin_i,
  input  logic       tick_i,
  input  logic       start_i,
  input  logic       pause_i,
  input  logic       eoq_i,
  input  logic       done_flag_i,
  output logic       active_o,
  output logic       ovr_set_o
);
  scan_mode_e mode;
  logic       pin_q;
  logic       pin_rise;

  assign mode     = scan_mode_e'(mode_i);
  assign pin_rise = pin_i & ~pin_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q    <= 1'b0;
      active_o <= 1'b0;
    end else begin
      pin_q <= pin_i;
      if (start_i)
        active_o <= 1'b1;
      else if (pause_i || eoq_i)
        active_o <= 1'b0;
    end
  end

  // The trigger that causes an overrun is dropped; the scan keeps running.
  always_comb begin
    case (mode)
      M_PIN_ONCE, M_PIN_LOOP: ovr_set_o = pin_rise & active_o;
      M_TMR_ONCE, M_TMR_LOOP: ovr_set_o = tick_i & active_o;
      M_GATED:                ovr_set_o = pin_i & eoq_i & done_flag_i;
      default:                ovr_set_o = 1'b0;
    endcase
  end

  p_sw_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (mode_i <= 3'd2) |-> !ovr_set_o);
  p_start_active_r2: assert property (@(posedge clk) disable iff (rst)
    start_i |=> active_o);
  p_ovr_needs_active_r3: assert property (@(posedge clk) disable iff (rst)
    (ovr_set_o && mode_i != 3'd7) |-> active_o);
endmodule

// File: rtl/qscan_flag_cell.sv
module qscan_flag_cell (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic flag_o
);
  logic arm_q;
  logic clr_ok;

  assign clr_ok = wr_i & ~wbit_i & arm_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_o <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      if (set_i)
        flag_o <= 1'b1;
      else if (clr_ok)
        flag_o <= 1'b0;

      if (set_i || clr_ok)
        arm_q <= 1'b0;
      else if (rd_i)
        arm_q <= flag_o;
    end
  end

  p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
    set_i |=> flag_o);
  p_keep_unarmed_r9: assert property (@(posedge clk) disable iff (rst)
    (flag_o && !arm_q) |=> flag_o);
endmodule

// File: rtl/qscan_flag_unit.sv
module qscan_flag_unit
  import qscan_pkg::*;
#(
  parameter int NF = FLAG_N
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    mode_i,
  input  logic          pin_i,
  input  logic          tick_i,
  input  logic          start_i,
  input  logic          pause_i,
  input  logic          eoq_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [NF-1:0] wdata_i,
  input  logic [NF-1:0] irq_en_i,
  output logic [NF-1:0] rdata_o,
  output logic [NF-1:0] flags_o,
  output logic [NF-1:0] irq_o,
  output logic          active_o
);
  logic          ovr_set;
  logic [NF-1:0] set_vec;

  qscan_trig_ctl u_ctl (
    .clk        (clk),
    .rst        (rst),
    .mode_i     (mode_i),
    .pin_i      (pin_i),
    .tick_i     (tick_i),
    .start_i    (start_i),
    .pause_i    (pause_i),
    .eoq_i      (eoq_i),
    .done_flag_i(flags_o[FLAG_DONE]),
    .active_o   (active_o),
    .ovr_set_o  (ovr_set)
  );

  always_comb begin
    set_vec             = '0;
    set_vec[FLAG_DONE]  = eoq_i;
    set_vec[FLAG_PAUSE] = pause_i;
    set_vec[FLAG_OVR]   = ovr_set;
  end

  for (genvar i = 0; i < NF; i++) begin : g_flag
    qscan_flag_cell u_cell (
      .clk   (clk),
      .rst   (rst),
      .set_i (set_vec[i]),
      .rd_i  (rd_i),
      .wr_i  (wr_i),
      .wbit_i(wdata_i[i]),
      .flag_o(flags_o[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata_o <= '0;
    else if (rd_i)
      rdata_o <= flags_o;
  end

  assign irq_o = flags_o & irq_en_i;

  p_read_r8: assert property (@(posedge clk) disable iff (rst)
    rd_i |=> (rdata_o == $past(flags_o)));
  p_eoq_done_r7: assert property (@(posedge clk) disable iff (rst)
    eoq_i |=> flags_o[FLAG_DONE]);
endmodule

// File: tb/sim_qscan_flag_unit.sv
`timescale 1ns/1ps
module sim_qscan_flag_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] mode_i = 3'd0;
  logic       pin_i = 1'b0, tick_i = 1'b0, start_i = 1'b0, pause_i = 1'b0, eoq_i = 1'b0;
  logic       rd_i = 1'b0, wr_i = 1'b0;
  logic [2:0] wdata_i = 3'b111, irq_en_i = 3'b000;
  logic [2:0] rdata_o, flags_o, irq_o;
  logic       active_o;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  always #2 clk = ~clk;

  qscan_flag_unit u0 (
    .clk(clk), .rst(rst), .mode_i(mode_i), .pin_i(pin_i), .tick_i(tick_i),
    .start_i(start_i), .pause_i(pause_i), .eoq_i(eoq_i), .rd_i(rd_i), .wr_i(wr_i),
    .wdata_i(wdata_i), .irq_en_i(irq_en_i), .rdata_o(rdata_o), .flags_o(flags_o),
    .irq_o(irq_o), .active_o(active_o)
  );

  // reference model
  logic [2:0] m_flag, m_arm, m_rdata;
  logic       m_act, m_pinq;

  function automatic logic f_ovr(logic [2:0] md, logic rise, logic tk, logic act,
                                 logic gate, logic eq, logic dn);
    case (md)
      3'd3, 3'd4: return rise & act;
      3'd5, 3'd6: return tk & act;
      3'd7:       return gate & eq & dn;
      default:    return 1'b0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_flag <= '0; m_arm <= '0; m_rdata <= '0; m_act <= 1'b0; m_pinq <= 1'b0;
    end else begin
      logic [2:0] s;
      logic [2:0] nf, na;
      s = {f_ovr(mode_i, pin_i & ~m_pinq, tick_i, m_act, pin_i, eoq_i, m_flag[0]),
           pause_i, eoq_i};
      for (int i = 0; i < 3; i++) begin
        logic c;
        c = wr_i & ~wdata_i[i] & m_arm[i];
        nf[i] = s[i] ? 1'b1 : (c ? 1'b0 : m_flag[i]);
        na[i] = (s[i] | c) ? 1'b0 : (rd_i ? m_flag[i] : m_arm[i]);
      end
      m_flag <= nf;
      m_arm  <= na;
      if (rd_i) m_rdata <= m_flag;
      m_pinq <= pin_i;
      if (start_i) m_act <= 1'b1;
      else if (pause_i || eoq_i) m_act <= 1'b0;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !ended) begin
      chk("R3/R6/R7/R10 model flags", {29'd0, flags_o}, {29'd0, m_flag});
      chk("R2 model active", {31'd0, active_o}, {31'd0, m_act});
      chk("R8 model rdata", {29'd0, rdata_o}, {29'd0, m_rdata});
      chk("R11 model irq", {29'd0, irq_o}, {29'd0, m_flag & irq_en_i});
    end
  end

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    start_i = 0; pause_i = 0; eoq_i = 0; tick_i = 0; rd_i = 0; wr_i = 0; wdata_i = 3'b111;
  endtask

  task automatic clear_all();
    rd_i = 1; cyc();
    wr_i = 1; wdata_i = 3'b000; cyc();
  endtask

  task automatic finish_run();
    ended = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    cyc(); cyc(); cyc();
    rst = 0;
    cyc();
    chk("R1 reset flags", {29'd0, flags_o}, 0);
    chk("R1 reset active", {31'd0, active_o}, 0);
    chk("R1 reset rdata", {29'd0, rdata_o}, 0);

    mode_i = 3'd3; start_i = 1; cyc();
    chk("R2 active after start", {31'd0, active_o}, 1);
    pin_i = 1; cyc();
    chk("R3 R4 pin overrun", {31'd0, flags_o[2]}, 1);
    chk("R3 scan unaffected", {31'd0, active_o}, 1);
    pin_i = 0; cyc();
    eoq_i = 1; cyc();
    chk("R2 active ends on eoq", {31'd0, active_o}, 0);
    chk("R7 completion", {31'd0, flags_o[0]}, 1);
    rd_i = 1; cyc();
    chk("R8 read data", {29'd0, rdata_o}, 3'b101);
    wr_i = 1; wdata_i = 3'b000; cyc();
    chk("R8 clear after read", {29'd0, flags_o}, 0);

    mode_i = 3'd5; start_i = 1; cyc();
    tick_i = 1; cyc();
    chk("R4 timer overrun", {31'd0, flags_o[2]}, 1);
    pause_i = 1; cyc();
    chk("R7 pause flag", {31'd0, flags_o[1]}, 1);
    chk("R2 active ends on pause", {31'd0, active_o}, 0);
    wr_i = 1; wdata_i = 3'b000; cyc();
    chk("R9 unarmed write 0", {29'd0, flags_o}, 3'b110);
    rd_i = 1; cyc();
    wr_i = 1; wdata_i = 3'b111; cyc();
    chk("R9 write 1 ignored", {29'd0, flags_o}, 3'b110);

    start_i = 1; cyc();
    tick_i = 1; wr_i = 1; wdata_i = 3'b000; cyc();
    chk("R10 set beats clear", {31'd0, flags_o[2]}, 1);
    chk("R8 armed pause cleared", {31'd0, flags_o[1]}, 0);
    wr_i = 1; wdata_i = 3'b000; cyc();
    chk("R10 set disarms", {31'd0, flags_o[2]}, 1);

    clear_all();
    mode_i = 3'd1; tick_i = 1; pin_i = 1; cyc();
    chk("R5 software mode no overrun", {31'd0, flags_o[2]}, 0);
    pin_i = 0; mode_i = 3'd2; tick_i = 1; cyc();
    pin_i = 1; cyc();
    chk("R5 software loop no overrun", {31'd0, flags_o[2]}, 0);
    pin_i = 0; eoq_i = 1; cyc();
    clear_all();

    mode_i = 3'd7; pin_i = 1; start_i = 1; cyc();
    eoq_i = 1; cyc();
    chk("R6 first eoq", {29'd0, flags_o}, 3'b001);
    eoq_i = 1; cyc();
    chk("R6 second eoq overrun", {31'd0, flags_o[2]}, 1);
    clear_all();
    eoq_i = 1; cyc();
    clear_all();
    eoq_i = 1; cyc();
    chk("R6 cleared between, no overrun", {29'd0, flags_o}, 3'b001);
    irq_en_i = 3'b111; #1;
    chk("R11 irq enabled", {29'd0, irq_o}, 3'b001);
    irq_en_i = 3'b110; #1;
    chk("R11 irq masked", {29'd0, irq_o}, 3'b000);
    pin_i = 0;
    cyc();

    for (int n = 0; n < 5000; n++) begin
      if ($urandom % 60 == 0) mode_i = 3'($urandom % 8);
      if ($urandom % 5 == 0) pin_i = ~pin_i;
      tick_i  = ($urandom % 7) == 0;
      start_i = ($urandom % 6) == 0;
      pause_i = ($urandom % 14) == 0;
      eoq_i   = ($urandom % 9) == 0;
      rd_i    = ($urandom % 4) == 0;
      wr_i    = ($urandom % 5) == 0;
      wdata_i = 3'($urandom);
      if ($urandom % 30 == 0) irq_en_i = 3'($urandom);
      cyc();
    end
    finish_run();
  end
endmodule